// File: doc/BRIEF.md
# Wake-Up Packet Frame Detector

This block sits on the receive path and checks each incoming Ethernet frame, one byte at a time, for a wake-up pattern addressed to this station. A frame qualifies when its payload holds a synchronization run of six 0xFF bytes, followed at once by sixteen back-to-back copies of the 48-bit station address. The destination field must also pass, unless the relaxed destination mode is selected. When a frame qualifies, the block emits a one-cycle detect pulse that drives the wake-packet status bit kept elsewhere.

Bytes arrive with a valid strobe. Start-of-frame and end-of-frame flags ride on the first and last valid bytes. Byte index 0 is the byte that carries start-of-frame. Indices 0 to 5 are the destination address and 6 to 11 are the source address. The pattern search runs over index 12 onward. CRC checking, the receive MAC and the status register are outside this block.

Top module: `wake_frame_detect`

## Requirements
- R1: After reset, `detect_o` is 0, and it stays 0 in any cycle that does not follow the final byte of a qualifying pattern.
- R2: While `wake_mode_i` is 0, no frame produces a detect.
- R3: With `any_dest_i` = 0, a detect needs frame bytes 0..5 to equal `station_addr_i` in wire order: byte 0 is bits [7:0] and byte 5 is bits [47:40].
- R4: With `any_dest_i` = 1, the destination bytes are not compared, so unicast, multicast and broadcast frames can all produce a detect.
- R5: The pattern is six consecutive 0xFF bytes followed by 16 consecutive copies of the station address. Each copy is sent bits [7:0] first and bits [47:40] last. The pattern may start at any byte index of 12 or above. Bytes 0..11 never count toward it.
- R6: `any_dest_i` = 1 does not relax the pattern: a frame with a broadcast destination and an incorrect pattern produces no detect.
- R7: Any byte that differs from the expected pattern byte restarts the search. If that byte is 0xFF, it counts as the first byte of a new sync run; otherwise the sync count returns to zero.
- R8: `detect_o` is high for exactly one cycle, in the cycle after the last byte of the 16th copy is accepted. A frame produces at most one detect, even if a second full pattern follows.
- R9: A frame that ends (end-of-frame on a valid byte) before the pattern completes produces no detect. Valid bytes after end-of-frame and before the next start-of-frame are ignored.
- R10: Start-of-frame on a valid byte discards any partial match. Cycles with `byte_vld_i` = 0 inside a frame leave the match state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_vld_i | input | 1 | Byte strobe; the other byte inputs are sampled only when it is 1 |
| byte_i | input | 8 | Received byte |
| sof_i | input | 1 | Marks the first byte of a frame |
| eof_i | input | 1 | Marks the last byte of a frame |
| station_addr_i | input | 48 | Station address; bits [7:0] go on the wire first |
| wake_mode_i | input | 1 | Enables detection |
| any_dest_i | input | 1 | 1: skip the destination compare |
| detect_o | output | 1 | One-cycle wake-packet detect pulse |

## Verification
The detector has only one output, so a wrong internal count or flag appears as a detect pulse that is missing, extra or one cycle late. The bench compares `detect_o` in every cycle, not only at the end of each frame. A sync counter, copy counter or byte-position counter that is off by one moves the pulse, or removes it, within the same frame. A destination flag or frame-open flag that is left stale by a previous frame causes an unexpected pulse, or a missing one, in the next frame. Frames that end early, frames that stop without end-of-frame, and frames that are restarted by start-of-frame are used to expose state that is not cleared.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned ADDR_W     = 8 * ADDR_BYTES;
  localparam int unsigned HDR_BYTES  = 2 * ADDR_BYTES;
  localparam int unsigned SYNC_LEN   = 6;
  localparam int unsigned COPIES     = 16;
  localparam logic [7:0]  SYNC_BYTE  = 8'hFF;
endpackage

// File: rtl/wake_dest_check.sv
module wake_dest_check
  import wake_pkg::*;
#(
  parameter int unsigned NBYTES = ADDR_BYTES,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  first_i,
  input  logic                  step_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [7:0]            byte_i,
  input  logic [8*NBYTES-1:0]   addr_i,
  output logic                  dest_ok_o
);
  localparam int unsigned SEL_W = $clog2(NBYTES);

  logic             dest_ok_q;
  logic [SEL_W-1:0] sel;
  logic [7:0]       exp_byte;

  assign sel      = idx_i[SEL_W-1:0];
  assign exp_byte = addr_i[8*sel +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dest_ok_q <= 1'b0;
    else if (first_i) dest_ok_q <= (byte_i == addr_i[7:0]);
    else if (step_i && (idx_i < IDX_W'(NBYTES)))
      dest_ok_q <= dest_ok_q && (byte_i == exp_byte);
  end

  assign dest_ok_o = dest_ok_q;
endmodule

// File: rtl/wake_pattern_match.sv
module wake_pattern_match
  import wake_pkg::*;
#(
  parameter int unsigned NBYTES   = ADDR_BYTES,
  parameter int unsigned SYNC_CNT = SYNC_LEN,
  parameter int unsigned NCOPIES  = COPIES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                step_i,
  input  logic [7:0]          byte_i,
  input  logic [8*NBYTES-1:0] addr_i,
  output logic                hit_o
);
  localparam int unsigned SW = $clog2(SYNC_CNT + 1);
  localparam int unsigned CW = $clog2(NCOPIES);
  localparam int unsigned PW = $clog2(NBYTES);

  logic [SW-1:0] sync_q;
  logic [CW-1:0] copy_q;
  logic [PW-1:0] pos_q;
  logic [7:0]    exp_byte;
  logic          in_copies, byte_ok, is_sync, last_pos, last_copy;

  assign exp_byte  = addr_i[8*pos_q +: 8];
  assign in_copies = (sync_q == SW'(SYNC_CNT));
  assign is_sync   = (byte_i == SYNC_BYTE);
  assign byte_ok   = (byte_i == exp_byte);
  assign last_pos  = (pos_q == PW'(NBYTES - 1));
  assign last_copy = (copy_q == CW'(NCOPIES - 1));
  assign hit_o     = step_i && in_copies && byte_ok && last_pos && last_copy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      copy_q <= '0;
      pos_q  <= '0;
    end else if (clear_i) begin
      sync_q <= '0;
      copy_q <= '0;
      pos_q  <= '0;
    end else if (step_i) begin
      if (!in_copies) begin
        sync_q <= is_sync ? sync_q + SW'(1) : '0;
      end else if (byte_ok) begin
        if (last_pos) begin
          pos_q <= '0;
          if (last_copy) begin
            sync_q <= '0;
            copy_q <= '0;
          end else begin
            copy_q <= copy_q + CW'(1);
          end
        end else begin
          pos_q <= pos_q + PW'(1);
        end
      end else begin
        // mismatching sync byte opens a new run
        sync_q <= is_sync ? SW'(1) : '0;
        copy_q <= '0;
        pos_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/wake_frame_detect.sv
module wake_frame_detect
  import wake_pkg::*;
#(
  parameter int unsigned NBYTES   = ADDR_BYTES,
  parameter int unsigned SYNC_CNT = SYNC_LEN,
  parameter int unsigned NCOPIES  = COPIES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                byte_vld_i,
  input  logic [7:0]          byte_i,
  input  logic                sof_i,
  input  logic                eof_i,
  input  logic [8*NBYTES-1:0] station_addr_i,
  input  logic                wake_mode_i,
  input  logic                any_dest_i,
  output logic                detect_o
);
  localparam int unsigned HDR   = 2 * NBYTES;
  localparam int unsigned IDX_W = $clog2(HDR + 1);

  logic             in_frame_q, done_q, detect_q;
  logic [IDX_W-1:0] hdr_cnt_q, cur_idx;
  logic             first_byte, frame_byte, payload, hit, fire, dest_ok;

  assign first_byte = byte_vld_i && sof_i;
  assign frame_byte = byte_vld_i && (sof_i || in_frame_q);
  assign cur_idx    = sof_i ? '0 : hdr_cnt_q;
  assign payload    = frame_byte && (cur_idx == IDX_W'(HDR));

  wake_dest_check #(.NBYTES(NBYTES), .IDX_W(IDX_W)) u_dest (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .first_i  (first_byte),
    .step_i   (frame_byte && !sof_i),
    .idx_i    (cur_idx),
    .byte_i   (byte_i),
    .addr_i   (station_addr_i),
    .dest_ok_o(dest_ok)
  );

  wake_pattern_match #(.NBYTES(NBYTES), .SYNC_CNT(SYNC_CNT), .NCOPIES(NCOPIES)) u_pat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(first_byte),
    .step_i (payload && !done_q),
    .byte_i (byte_i),
    .addr_i (station_addr_i),
    .hit_o  (hit)
  );

  assign fire = hit && wake_mode_i && (any_dest_i || dest_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      hdr_cnt_q  <= '0;
      done_q     <= 1'b0;
      detect_q   <= 1'b0;
    end else begin
      detect_q <= fire;
      if (frame_byte) begin
        in_frame_q <= !eof_i;
        if (cur_idx < IDX_W'(HDR)) hdr_cnt_q <= cur_idx + IDX_W'(1);
      end
      if (first_byte) done_q <= 1'b0;
      else if (fire)  done_q <= 1'b1;
    end
  end

  assign detect_o = detect_q;
endmodule

// File: rtl/wake_frame_detect_chk.sv
module wake_frame_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic byte_vld_i,
  input logic wake_mode_i,
  input logic any_dest_i,
  input logic frame_byte,
  input logic dest_ok,
  input logic detect_o
);
  // R8
  detect_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |=> !detect_o);
  // R2
  mode_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |-> $past(wake_mode_i));
  // R10
  detect_on_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |-> $past(byte_vld_i));
  // R3
  dest_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |-> ($past(any_dest_i) || $past(dest_ok)));
  // R9
  in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |-> $past(frame_byte));
endmodule

bind wake_frame_detect wake_frame_detect_chk u_chk (.*);

// File: tb/tb_wake_frame_detect.sv
module tb_wake_frame_detect;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        sof_i = 1'b0;
  logic        eof_i = 1'b0;
  logic [47:0] station_addr_i = 48'h5A_34_12_AB_CD_0E;
  logic        wake_mode_i = 1'b1;
  logic        any_dest_i = 1'b0;
  logic        detect_o;

  wake_frame_detect dut (.*);

  always #5 clk_i = ~clk_i;

  typedef struct { logic exp; string tag; } item_t;
  item_t       sb_q[$];
  logic [7:0]  fq[$];
  int          n_checks = 0, n_fail = 0;
  bit          finished = 1'b0;

  localparam int PAT_LEN = 6 + 6 * 16;

  function automatic logic [7:0] abyte(logic [47:0] a, int i);
    return a[8*i +: 8];
  endfunction

  // Expected detect index from the requirements; -1 for none.
  function automatic int ref_detect(logic [7:0] f[$], int n_used);
    int pos = 0;
    bit dok = 1'b1;
    logic [7:0] e;
    if (!wake_mode_i) return -1;
    for (int i = 0; i < 6; i++)
      if (i >= n_used || f[i] != abyte(station_addr_i, i)) dok = 1'b0;
    for (int i = 12; i < n_used; i++) begin
      e = (pos < 6) ? 8'hFF : abyte(station_addr_i, (pos - 6) % 6);
      if (f[i] == e) begin
        pos++;
        if (pos == PAT_LEN) return (dok || any_dest_i) ? i : -1;
      end else begin
        pos = (f[i] == 8'hFF) ? 1 : 0;
      end
    end
    return -1;
  endfunction

  task automatic push(logic e, string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      byte_vld_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0;
      push(1'b0, "R1");
    end
  endtask

  // send fq; with_sof/with_eof mark ends, gap inserts idle cycles
  task automatic send(string tag, bit with_sof, bit with_eof, bit gap);
    int det;
    det = with_sof ? ref_detect(fq, fq.size()) : -1;
    for (int i = 0; i < fq.size(); i++) begin
      @(negedge clk_i);
      byte_vld_i = 1'b1;
      byte_i     = fq[i];
      sof_i      = with_sof && (i == 0);
      eof_i      = with_eof && (i == fq.size() - 1);
      push(i == det, tag);
      if (gap && (i % 7 == 3)) begin
        @(negedge clk_i);
        byte_vld_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0;
        push(1'b0, tag);
      end
    end
    idle(2);
    fq.delete();
  endtask

  task automatic add_addr(logic [47:0] a);
    for (int i = 0; i < 6; i++) fq.push_back(abyte(a, i));
  endtask
  task automatic add_rep(logic [7:0] b, int n);
    for (int i = 0; i < n; i++) fq.push_back(b);
  endtask
  task automatic add_copies(logic [47:0] a, int n);
    for (int i = 0; i < n; i++) add_addr(a);
  endtask
  task automatic add_copies_rev(logic [47:0] a, int n);
    for (int c = 0; c < n; c++)
      for (int i = 5; i >= 0; i--) fq.push_back(abyte(a, i));
  endtask
  task automatic hdr(logic [47:0] d);
    add_addr(d);
    add_addr(48'h00_11_22_33_44_02);
  endtask

  always @(posedge clk_i) begin
    #2;
    if (!finished && sb_q.size() != 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (detect_o !== it.exp) begin
        n_fail++;
        $display("FAIL %s: detect_o=%b expected %b at %0t", it.tag, detect_o, it.exp, $time);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_checks++;
    if (detect_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: detect_o=%b expected 0 in reset", detect_o);
    end
    rst_ni = 1'b1;
    idle(2);

    // R5 R3 R8: exact destination, filler, sync, 16 copies
    hdr(station_addr_i); add_rep(8'h3C, 5); add_rep(8'hFF, 6); add_copies(station_addr_i, 16);
    add_rep(8'h00, 4);
    send("R5", 1, 1, 0);

    // R3: destination differs in last byte
    hdr(station_addr_i ^ 48'h01_00_00_00_00_00); add_rep(8'hFF, 6); add_copies(station_addr_i, 16);
    send("R3", 1, 1, 0);

    // R4: broadcast destination accepted in relaxed mode
    any_dest_i = 1'b1;
    hdr(48'hFF_FF_FF_FF_FF_FF); add_rep(8'hFF, 6); add_copies(station_addr_i, 16);
    send("R4", 1, 1, 0);

    // R6: relaxed mode, wrong pattern (15 copies)
    hdr(48'hFF_FF_FF_FF_FF_FF); add_rep(8'hFF, 6); add_copies(station_addr_i, 15); add_rep(8'h00, 6);
    send("R6", 1, 1, 0);
    any_dest_i = 1'b0;

    // R5: copies with byte order reversed
    hdr(station_addr_i); add_rep(8'hFF, 6); add_copies_rev(station_addr_i, 16);
    send("R5", 1, 1, 0);

    // R5: sync run placed in the source field does not count
    add_addr(station_addr_i); add_rep(8'hFF, 6); add_copies(station_addr_i, 16);
    send("R5", 1, 1, 0);

    // R2: mode off
    wake_mode_i = 1'b0;
    hdr(station_addr_i); add_rep(8'hFF, 6); add_copies(station_addr_i, 16);
    send("R2", 1, 1, 0);
    wake_mode_i = 1'b1;

    // R9: frame ends after 15 copies
    hdr(station_addr_i); add_rep(8'hFF, 6); add_copies(station_addr_i, 15);
    send("R9", 1, 1, 0);

    // R9: remainder sent without start-of-frame is ignored
    add_rep(8'hFF, 6); add_copies(station_addr_i, 16);
    send("R9", 0, 1, 0);

    // R7: broken copy, mismatching 0xFF starts new run of six
    hdr(station_addr_i); add_rep(8'hFF, 6); add_copies(station_addr_i, 3);
    add_rep(8'hFF, 6); add_copies(station_addr_i, 16);
    send("R7", 1, 1, 0);

    // R7: seven 0xFF before copies breaks the run
    hdr(station_addr_i); add_rep(8'hFF, 7); add_copies(station_addr_i, 16);
    send("R7", 1, 1, 0);

    // R8: two full patterns, one detect
    hdr(station_addr_i); add_rep(8'hFF, 6); add_copies(station_addr_i, 16);
    add_rep(8'hFF, 6); add_copies(station_addr_i, 16);
    send("R8", 1, 1, 0);

    // R10: frame cut without eof, then a fresh frame with gaps
    hdr(station_addr_i); add_rep(8'hFF, 6); add_copies(station_addr_i, 10);
    send("R10", 1, 0, 0);
    hdr(station_addr_i); add_rep(8'hFF, 6); add_copies(station_addr_i, 16);
    send("R10", 1, 1, 1);

    // R10: sof mid-frame discards partial copies
    hdr(station_addr_i); add_rep(8'hFF, 6); add_copies(station_addr_i, 12);
    send("R10", 1, 0, 0);
    hdr(station_addr_i); add_copies(station_addr_i, 4);
    send("R10", 1, 1, 0);

    idle(3);
    wait (sb_q.size() == 0);
    @(negedge clk_i);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule